// File: doc/BRIEF.md
# Depth Test and Buffer Copy Unit

This unit sits between a rasteriser and two external pixel memories: a 24-bit depth store and a colour frame buffer of the same word width. In fragment mode it takes one fragment at a time (x, y, depth, colour) over a valid/ready handshake. It reads the stored depth at that pixel and keeps the fragment only if it is nearer to the viewer, meaning numerically smaller. A kept fragment writes its colour, and also its depth unless depth writes are switched off. A configuration bit can bypass the comparison so that every fragment is kept.

In copy mode the depth store serves as an off-screen save area. A start pulse with a direction bit and a rectangle (base x, base y, width, height) makes the unit walk the rectangle row by row, left to right within each row. It moves one word per cycle from the colour buffer into the depth store (save), or from the depth store back into the colour buffer (restore). No pixel data crosses the unit's edge in either direction. A one-cycle done pulse ends the walk. Pixel addresses are formed as `{y, x}`, so the memories are laid out as 2^Y_W rows of 2^X_W words. Both memories return read data on the cycle after the read enable.

Top module: `zbu_unit`

## Requirements
- R1: During and directly after synchronous active-low reset, frag_ready is 1, cp_done is 0 and all four memory enables (zr_en, zw_en, cr_en, cw_en) are 0.
- R2: With the test enabled, a fragment whose depth is strictly less than the stored depth writes its colour to cw at address {y,x}, and its depth to zw at the same address when depth writes are enabled.
- R3: With the test enabled, a fragment whose depth is equal to or greater than the stored depth writes neither memory.
- R4: With cfg_test_en at 0, every fragment is kept, whatever the stored depth.
- R5: With cfg_zwrite_en at 0, a kept fragment writes colour only, and the depth store keeps its old value.
- R6: The cycle after a fragment is accepted, zr_en is asserted at {y,x}. The writes, if any, occur in the cycle after that. frag_ready stays 0 from acceptance until the cycle after the write cycle, which gives one fragment every three cycles.
- R7: Save (cp_dir = 0) reads colour word k of the rectangle in cycle k+1 after the start edge. It writes that word into the depth store at the same address one cycle later. Pixels are visited in raster order, and the colour buffer is not written.
- R8: Restore (cp_dir = 1) reads depth word k and writes it into the colour buffer at the same address one cycle later, with the same ordering. The depth store is not written.
- R9: cp_done is a one-cycle pulse in cycle N+2 after the start edge for a rectangle of N pixels. When the width or height is 0, it arrives in cycle 1 and no memory is accessed.
- R10: frag_ready is 0 from the accepted start until the done cycle, and also in any cycle where cp_start is high. A cp_start that arrives while a fragment is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_test_en | input | 1 | 1: depth comparison active; 0: keep every fragment |
| cfg_zwrite_en | input | 1 | 1: kept fragments update the depth store |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Fragment can be accepted |
| frag_x | input | X_W | Fragment column |
| frag_y | input | Y_W | Fragment row |
| frag_z | input | WORD_W | Fragment depth |
| frag_color | input | WORD_W | Fragment colour |
| cp_start | input | 1 | Start a rectangle copy |
| cp_dir | input | 1 | 0: colour to depth store (save); 1: depth store to colour (restore) |
| cp_x | input | X_W | Rectangle base column |
| cp_y | input | Y_W | Rectangle base row |
| cp_w | input | X_W+1 | Rectangle width in pixels |
| cp_h | input | Y_W+1 | Rectangle height in pixels |
| cp_done | output | 1 | Copy finished (one cycle) |
| zr_en | output | 1 | Depth store read enable |
| zr_addr | output | X_W+Y_W | Depth store read address |
| zr_data | input | WORD_W | Depth store read data, one cycle after zr_en |
| zw_en | output | 1 | Depth store write enable |
| zw_addr | output | X_W+Y_W | Depth store write address |
| zw_data | output | WORD_W | Depth store write data |
| cr_en | output | 1 | Colour buffer read enable |
| cr_addr | output | X_W+Y_W | Colour buffer read address |
| cr_data | input | WORD_W | Colour buffer read data, one cycle after cr_en |
| cw_en | output | 1 | Colour buffer write enable |
| cw_addr | output | X_W+Y_W | Colour buffer write address |
| cw_data | output | WORD_W | Colour buffer write data |

## Verification
The bench builds the unit with X_W = 3 and Y_W = 3 and keeps the 24-bit word width. That gives an 8 by 8 pixel field of 64 words per memory, and the bench models both memories in full. At this size every stored word can be compared with an independently kept expectation after each scenario. Rectangles can reach the field edges, and the complete order of depth-store writes during a copy can be logged and checked against raster order. The full 24-bit width keeps the equal-depth case and the maximum clear value (all ones) at their real sizes.

// File: rtl/zbu_pkg.sv
// Shared types for the depth test and buffer copy unit.
// Assumes nothing beyond being compiled before the modules that import it.
package zbu_pkg;

    // Fragment sequencer states: wait, read stored depth, decide and write.
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_READ   = 2'd1,
        FR_DECIDE = 2'd2
    } frag_st_e;

    // Copy walker states.
    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_RUN   = 2'd1,
        CP_DRAIN = 2'd2,
        CP_DONE  = 2'd3
    } copy_st_e;

    // Copy direction as seen on cp_dir.
    typedef enum logic {
        DIR_SAVE    = 1'b0,
        DIR_RESTORE = 1'b1
    } copy_dir_e;

endpackage

// File: rtl/zbu_depth_cmp.sv
// Depth comparator: decides whether a fragment survives.
// Assumes unsigned depth words in which a smaller value is nearer the viewer.
module zbu_depth_cmp #(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] frag_z,
    input  logic [WORD_W-1:0] stored_z,
    input  logic              test_en,
    output logic              keep
);

    // Strict less-than wins; a bypassed test keeps everything.
    always_comb keep = !test_en || (frag_z < stored_z);

endmodule

// File: rtl/zbu_frag_engine.sv
// Fragment sequencer: accept, read stored depth, compare, write.
// Handles one fragment per three-cycle sequence so that a read never
// overtakes a pending write to the same pixel. Assumes read data returns
// exactly one cycle after rd_en.
module zbu_frag_engine
    import zbu_pkg::*;
#(
    parameter int X_W    = 11,
    parameter int Y_W    = 10,
    parameter int WORD_W = 24,
    localparam int ADDR_W = X_W + Y_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [X_W-1:0]    in_x,
    input  logic [Y_W-1:0]    in_y,
    input  logic [WORD_W-1:0] in_z,
    input  logic [WORD_W-1:0] in_c,
    input  logic              cfg_test_en,
    input  logic              cfg_zwrite_en,
    input  logic              block,
    output logic              idle,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              zw_en,
    output logic [ADDR_W-1:0] zw_addr,
    output logic [WORD_W-1:0] zw_data,
    output logic              cw_en,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [WORD_W-1:0] cw_data
);

    frag_st_e          st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] z_q;
    logic [WORD_W-1:0] c_q;
    logic              test_q;
    logic              zwr_q;
    logic              accept;
    logic              keep;

    // Handshake: only an idle sequencer with no copy pending takes a fragment.
    always_comb begin
        idle     = (st_q == FR_IDLE);
        in_ready = idle && !block;
        accept   = in_valid && in_ready;
    end

    // State progression through one read-compare-write sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FR_IDLE;
        end else begin
            case (st_q)
                FR_IDLE:   if (accept) st_q <= FR_READ;
                FR_READ:   st_q <= FR_DECIDE;
                FR_DECIDE: st_q <= FR_IDLE;
                default:   st_q <= FR_IDLE;
            endcase
        end
    end

    // Capture the fragment and the controls that apply to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            z_q    <= '0;
            c_q    <= '0;
            test_q <= 1'b1;
            zwr_q  <= 1'b1;
        end else if (accept) begin
            addr_q <= {in_y, in_x};
            z_q    <= in_z;
            c_q    <= in_c;
            test_q <= cfg_test_en;
            zwr_q  <= cfg_zwrite_en;
        end
    end

    zbu_depth_cmp #(.WORD_W(WORD_W)) u_cmp (
        .frag_z   (z_q),
        .stored_z (rd_data),
        .test_en  (test_q),
        .keep     (keep)
    );

    // Memory requests: read in READ, conditional writes in DECIDE.
    always_comb begin
        rd_en   = (st_q == FR_READ);
        rd_addr = addr_q;
        cw_en   = (st_q == FR_DECIDE) && keep;
        cw_addr = addr_q;
        cw_data = c_q;
        zw_en   = (st_q == FR_DECIDE) && keep && zwr_q;
        zw_addr = addr_q;
        zw_data = z_q;
    end

endmodule

// File: rtl/zbu_copy_engine.sv
// Rectangle copy walker: visits the pixels of a rectangle in raster order,
// issuing one source read per cycle and the matching destination write one
// cycle later. Assumes source data arrives one cycle after src_en and that
// base plus extent stays inside the field (coordinates wrap otherwise).
module zbu_copy_engine
    import zbu_pkg::*;
#(
    parameter int X_W    = 11,
    parameter int Y_W    = 10,
    parameter int WORD_W = 24,
    localparam int ADDR_W = X_W + Y_W,
    localparam int WX_W   = X_W + 1,
    localparam int HY_W   = Y_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [X_W-1:0]    base_x,
    input  logic [Y_W-1:0]    base_y,
    input  logic [WX_W-1:0]   width,
    input  logic [HY_W-1:0]   height,
    output logic              active,
    output logic              dir_restore,
    output logic              done,
    output logic              src_en,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [WORD_W-1:0] src_data,
    output logic              dst_en,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [WORD_W-1:0] dst_data
);

    copy_st_e          st_q;
    copy_dir_e         dir_q;
    logic [X_W-1:0]    bx_q;
    logic [Y_W-1:0]    by_q;
    logic [WX_W-1:0]   w_q;
    logic [HY_W-1:0]   h_q;
    logic [X_W-1:0]    ox_q;
    logic [Y_W-1:0]    oy_q;
    logic              pend_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [X_W-1:0]    col;
    logic [Y_W-1:0]    row;
    logic              last_x;
    logic              last_y;
    logic              empty;

    // Current pixel address and end-of-row / end-of-rectangle detection.
    always_comb begin
        col      = bx_q + ox_q;
        row      = by_q + oy_q;
        src_addr = {row, col};
        last_x   = ({1'b0, ox_q} == (w_q - WX_W'(1)));
        last_y   = ({1'b0, oy_q} == (h_q - HY_W'(1)));
        empty    = (width == '0) || (height == '0);
    end

    // Walker state and cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CP_IDLE;
            dir_q <= DIR_SAVE;
            bx_q  <= '0;
            by_q  <= '0;
            w_q   <= '0;
            h_q   <= '0;
            ox_q  <= '0;
            oy_q  <= '0;
        end else begin
            case (st_q)
                CP_IDLE: begin
                    if (start) begin
                        dir_q <= copy_dir_e'(dir);
                        bx_q  <= base_x;
                        by_q  <= base_y;
                        w_q   <= width;
                        h_q   <= height;
                        ox_q  <= '0;
                        oy_q  <= '0;
                        st_q  <= empty ? CP_DONE : CP_RUN;
                    end
                end
                CP_RUN: begin
                    if (last_x) begin
                        ox_q <= '0;
                        if (last_y) st_q <= CP_DRAIN;
                        else        oy_q <= oy_q + Y_W'(1);
                    end else begin
                        ox_q <= ox_q + X_W'(1);
                    end
                end
                CP_DRAIN: st_q <= CP_DONE;
                CP_DONE:  st_q <= CP_IDLE;
                default:  st_q <= CP_IDLE;
            endcase
        end
    end

    // One-stage write pipeline that follows the read by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            paddr_q <= '0;
        end else begin
            pend_q  <= (st_q == CP_RUN);
            paddr_q <= src_addr;
        end
    end

    // Outputs of the walker.
    always_comb begin
        active      = (st_q != CP_IDLE);
        dir_restore = (dir_q == DIR_RESTORE);
        done        = (st_q == CP_DONE);
        src_en      = (st_q == CP_RUN);
        dst_en      = pend_q;
        dst_addr    = paddr_q;
        dst_data    = src_data;
    end

endmodule

// File: rtl/zbu_unit.sv
// Depth test and buffer copy unit, top level.
// Routes the fragment sequencer and the copy walker onto the depth-store
// and colour-buffer ports. The two never run together: a copy starts only
// when the sequencer is idle, and fragments are refused during a copy.
// Assumes both memories have one-cycle read latency.
module zbu_unit
    import zbu_pkg::*;
#(
    parameter int X_W    = 11,
    parameter int Y_W    = 10,
    parameter int WORD_W = 24,
    localparam int ADDR_W = X_W + Y_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_test_en,
    input  logic              cfg_zwrite_en,
    input  logic              frag_valid,
    output logic              frag_ready,
    input  logic [X_W-1:0]    frag_x,
    input  logic [Y_W-1:0]    frag_y,
    input  logic [WORD_W-1:0] frag_z,
    input  logic [WORD_W-1:0] frag_color,
    input  logic              cp_start,
    input  logic              cp_dir,
    input  logic [X_W-1:0]    cp_x,
    input  logic [Y_W-1:0]    cp_y,
    input  logic [X_W:0]      cp_w,
    input  logic [Y_W:0]      cp_h,
    output logic              cp_done,
    output logic              zr_en,
    output logic [ADDR_W-1:0] zr_addr,
    input  logic [WORD_W-1:0] zr_data,
    output logic              zw_en,
    output logic [ADDR_W-1:0] zw_addr,
    output logic [WORD_W-1:0] zw_data,
    output logic              cr_en,
    output logic [ADDR_W-1:0] cr_addr,
    input  logic [WORD_W-1:0] cr_data,
    output logic              cw_en,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [WORD_W-1:0] cw_data
);

    logic              frag_idle;
    logic              copy_active;
    logic              copy_restore;
    logic              copy_go;
    logic              block;
    logic              f_rd_en;
    logic [ADDR_W-1:0] f_rd_addr;
    logic              f_zw_en;
    logic [ADDR_W-1:0] f_zw_addr;
    logic [WORD_W-1:0] f_zw_data;
    logic              f_cw_en;
    logic [ADDR_W-1:0] f_cw_addr;
    logic [WORD_W-1:0] f_cw_data;
    logic              c_src_en;
    logic [ADDR_W-1:0] c_src_addr;
    logic [WORD_W-1:0] c_src_data;
    logic              c_dst_en;
    logic [ADDR_W-1:0] c_dst_addr;
    logic [WORD_W-1:0] c_dst_data;

    // Copy start is taken only with both engines idle; it also blocks fragments.
    always_comb begin
        copy_go = cp_start && frag_idle && !copy_active;
        block   = copy_active || cp_start;
    end

    zbu_frag_engine #(.X_W(X_W), .Y_W(Y_W), .WORD_W(WORD_W)) u_frag (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (frag_valid),
        .in_ready      (frag_ready),
        .in_x          (frag_x),
        .in_y          (frag_y),
        .in_z          (frag_z),
        .in_c          (frag_color),
        .cfg_test_en   (cfg_test_en),
        .cfg_zwrite_en (cfg_zwrite_en),
        .block         (block),
        .idle          (frag_idle),
        .rd_en         (f_rd_en),
        .rd_addr       (f_rd_addr),
        .rd_data       (zr_data),
        .zw_en         (f_zw_en),
        .zw_addr       (f_zw_addr),
        .zw_data       (f_zw_data),
        .cw_en         (f_cw_en),
        .cw_addr       (f_cw_addr),
        .cw_data       (f_cw_data)
    );

    zbu_copy_engine #(.X_W(X_W), .Y_W(Y_W), .WORD_W(WORD_W)) u_copy (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (copy_go),
        .dir         (cp_dir),
        .base_x      (cp_x),
        .base_y      (cp_y),
        .width       (cp_w),
        .height      (cp_h),
        .active      (copy_active),
        .dir_restore (copy_restore),
        .done        (cp_done),
        .src_en      (c_src_en),
        .src_addr    (c_src_addr),
        .src_data    (c_src_data),
        .dst_en      (c_dst_en),
        .dst_addr    (c_dst_addr),
        .dst_data    (c_dst_data)
    );

    // Source data for the walker comes from whichever memory it reads.
    always_comb c_src_data = copy_restore ? zr_data : cr_data;

    // Depth store ports: fragment traffic, or copy source/destination.
    always_comb begin
        zr_en   = f_rd_en || (c_src_en && copy_restore);
        zr_addr = copy_active ? c_src_addr : f_rd_addr;
        zw_en   = f_zw_en || (c_dst_en && !copy_restore);
        zw_addr = copy_active ? c_dst_addr : f_zw_addr;
        zw_data = copy_active ? c_dst_data : f_zw_data;
    end

    // Colour buffer ports: read only for save, write for fragments or restore.
    always_comb begin
        cr_en   = c_src_en && !copy_restore;
        cr_addr = c_src_addr;
        cw_en   = f_cw_en || (c_dst_en && copy_restore);
        cw_addr = copy_active ? c_dst_addr : f_cw_addr;
        cw_data = copy_active ? c_dst_data : f_cw_data;
    end

endmodule

// File: rtl/zbu_unit_chk.sv
// Property checker for zbu_unit, attached with bind below.
// Observes ports and the walker's activity flag only.
module zbu_unit_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frag_valid,
    input logic              frag_ready,
    input logic              copy_active,
    input logic              cp_done,
    input logic              zr_en,
    input logic [ADDR_W-1:0] zr_addr,
    input logic              zw_en,
    input logic [ADDR_W-1:0] zw_addr,
    input logic              cr_en,
    input logic [ADDR_W-1:0] cr_addr,
    input logic              cw_en,
    input logic [ADDR_W-1:0] cw_addr
);

    // R6
    frag_accept_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_ready) |=> (zr_en && !frag_ready));

    // R6
    frag_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zr_en && !copy_active) |=> (!frag_ready && !zr_en));

    // R5
    frag_depth_needs_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zw_en && !copy_active) |-> cw_en);

    // R7
    save_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_en |=> (zw_en && !cw_en && (zw_addr == $past(cr_addr))));

    // R8
    restore_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zr_en && copy_active) |=> (cw_en && !zw_en && (cw_addr == $past(zr_addr))));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_done |=> !cp_done);

    // R10
    copy_blocks_frag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_active |-> !frag_ready);

    // R7
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_en && zr_en));

endmodule

bind zbu_unit zbu_unit_chk #(.ADDR_W(X_W + Y_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frag_valid  (frag_valid),
    .frag_ready  (frag_ready),
    .copy_active (copy_active),
    .cp_done     (cp_done),
    .zr_en       (zr_en),
    .zr_addr     (zr_addr),
    .zw_en       (zw_en),
    .zw_addr     (zw_addr),
    .cr_en       (cr_en),
    .cr_addr     (cr_addr),
    .cw_en       (cw_en),
    .cw_addr     (cw_addr)
);

// File: tb/zbu_unit_test.sv
// Directed bench for zbu_unit on an 8 x 8 field with both memories modelled.
module zbu_unit_test;

    localparam int X_W    = 3;
    localparam int Y_W    = 3;
    localparam int WORD_W = 24;
    localparam int ADDR_W = X_W + Y_W;
    localparam int NPIX   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_test_en = 1'b1;
    logic              cfg_zwrite_en = 1'b1;
    logic              frag_valid = 1'b0;
    logic              frag_ready;
    logic [X_W-1:0]    frag_x = '0;
    logic [Y_W-1:0]    frag_y = '0;
    logic [WORD_W-1:0] frag_z = '0;
    logic [WORD_W-1:0] frag_color = '0;
    logic              cp_start = 1'b0;
    logic              cp_dir = 1'b0;
    logic [X_W-1:0]    cp_x = '0;
    logic [Y_W-1:0]    cp_y = '0;
    logic [X_W:0]      cp_w = '0;
    logic [Y_W:0]      cp_h = '0;
    logic              cp_done;
    logic              zr_en;
    logic [ADDR_W-1:0] zr_addr;
    logic [WORD_W-1:0] zr_data = '0;
    logic              zw_en;
    logic [ADDR_W-1:0] zw_addr;
    logic [WORD_W-1:0] zw_data;
    logic              cr_en;
    logic [ADDR_W-1:0] cr_addr;
    logic [WORD_W-1:0] cr_data = '0;
    logic              cw_en;
    logic [ADDR_W-1:0] cw_addr;
    logic [WORD_W-1:0] cw_data;

    logic [WORD_W-1:0] zmem [NPIX];
    logic [WORD_W-1:0] cmem [NPIX];
    logic [WORD_W-1:0] ez   [NPIX];
    logic [WORD_W-1:0] ec   [NPIX];
    logic [ADDR_W-1:0] zlog [NPIX];
    int zlog_n = 0;
    int zw_cnt = 0;
    int cw_cnt = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    zbu_unit #(.X_W(X_W), .Y_W(Y_W), .WORD_W(WORD_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_test_en(cfg_test_en), .cfg_zwrite_en(cfg_zwrite_en),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_x(frag_x), .frag_y(frag_y), .frag_z(frag_z), .frag_color(frag_color),
        .cp_start(cp_start), .cp_dir(cp_dir), .cp_x(cp_x), .cp_y(cp_y),
        .cp_w(cp_w), .cp_h(cp_h), .cp_done(cp_done),
        .zr_en(zr_en), .zr_addr(zr_addr), .zr_data(zr_data),
        .zw_en(zw_en), .zw_addr(zw_addr), .zw_data(zw_data),
        .cr_en(cr_en), .cr_addr(cr_addr), .cr_data(cr_data),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data)
    );

    // Memory models: one-cycle read latency, write log for ordering checks.
    always @(posedge clk) begin
        if (zr_en) zr_data <= zmem[zr_addr];
        if (cr_en) cr_data <= cmem[cr_addr];
        if (zw_en) begin
            zmem[zw_addr] <= zw_data;
            if (zlog_n < NPIX) zlog[zlog_n] <= zw_addr;
            zlog_n <= zlog_n + 1;
            zw_cnt <= zw_cnt + 1;
        end
        if (cw_en) begin
            cmem[cw_addr] <= cw_data;
            cw_cnt <= cw_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare both memories against the expectation arrays.
    task automatic cmp_mem(input string tag);
        int mism = 0;
        for (int i = 0; i < NPIX; i++) begin
            if (zmem[i] !== ez[i] || cmem[i] !== ec[i]) mism++;
        end
        chk(mism == 0, tag, mism, 0);
    endtask

    // Offer one fragment and check the three-cycle sequence (R6).
    task automatic send_frag(input int x, input int y, input int z, input int c);
        @(negedge clk);
        frag_x = X_W'(x); frag_y = Y_W'(y);
        frag_z = WORD_W'(z); frag_color = WORD_W'(c);
        frag_valid = 1'b1;
        chk(frag_ready == 1'b1, "R6 ready before accept", int'(frag_ready), 1);
        @(negedge clk);
        frag_valid = 1'b0;
        chk(!frag_ready && zr_en && zr_addr == ADDR_W'({y[Y_W-1:0], x[X_W-1:0]}),
            "R6 read cycle", int'(zr_addr), (y << X_W) | x);
        @(negedge clk);
        chk(!frag_ready && !zr_en, "R6 decide cycle", int'(frag_ready), 0);
        @(negedge clk);
        chk(frag_ready == 1'b1, "R6 ready again", int'(frag_ready), 1);
    endtask

    // Run a copy and check done timing and ready blocking (R9, R10).
    task automatic run_copy(input bit dir, input int x, input int y, input int w, input int h);
        int n = w * h;
        int due = (n == 0) ? 1 : n + 2;
        int early = 0;
        int rdy = 0;
        @(negedge clk);
        cp_dir = dir; cp_x = X_W'(x); cp_y = Y_W'(y);
        cp_w = (X_W+1)'(w); cp_h = (Y_W+1)'(h);
        cp_start = 1'b1;
        @(negedge clk);
        cp_start = 1'b0;
        for (int k = 1; k < due; k++) begin
            if (cp_done) early++;
            if (frag_ready) rdy++;
            @(negedge clk);
        end
        chk(early == 0, "R9 no early done", early, 0);
        chk(rdy == 0, "R10 ready low during copy", rdy, 0);
        chk(cp_done == 1'b1, "R9 done in cycle N+2", int'(cp_done), 1);
        @(negedge clk);
        chk(cp_done == 1'b0 && frag_ready == 1'b1, "R9 done single cycle",
            int'(cp_done), 0);
    endtask

    task automatic t_reset;
        chk(frag_ready && !cp_done && !zr_en && !zw_en && !cr_en && !cw_en,
            "R1 reset outputs", {frag_ready, cp_done, zr_en, zw_en, cr_en, cw_en}, 6'b100000);
    endtask

    task automatic t_pass;
        send_frag(1, 2, 24'h000100, 24'hA1B2C3);
        ez[(2 << X_W) | 1] = 24'h000100;
        ec[(2 << X_W) | 1] = 24'hA1B2C3;
        cmp_mem("R2 nearer fragment written");
        send_frag(7, 7, 24'hFFFFFE, 24'h123456);
        ez[63] = 24'hFFFFFE;
        ec[63] = 24'h123456;
        cmp_mem("R2 corner pixel just below clear value");
    endtask

    task automatic t_fail;
        int zc = zw_cnt;
        int cc = cw_cnt;
        send_frag(1, 2, 24'h000100, 24'h0BAD01);
        send_frag(1, 2, 24'h000200, 24'h0BAD02);
        chk(zw_cnt == zc && cw_cnt == cc, "R3 equal/farther writes nothing",
            zw_cnt - zc + cw_cnt - cc, 0);
        cmp_mem("R3 memories unchanged");
    endtask

    task automatic t_test_off;
        cfg_test_en = 1'b0;
        send_frag(1, 2, 24'h800000, 24'h00FF00);
        cfg_test_en = 1'b1;
        ez[(2 << X_W) | 1] = 24'h800000;
        ec[(2 << X_W) | 1] = 24'h00FF00;
        cmp_mem("R4 bypassed test keeps farther fragment");
    endtask

    task automatic t_zwrite_off;
        int zc = zw_cnt;
        cfg_zwrite_en = 1'b0;
        send_frag(3, 3, 24'h000010, 24'h55AA55);
        cfg_zwrite_en = 1'b1;
        ec[(3 << X_W) | 3] = 24'h55AA55;
        chk(zw_cnt == zc, "R5 no depth write", zw_cnt - zc, 0);
        cmp_mem("R5 colour only");
    endtask

    task automatic t_save;
        int base = zlog_n;
        int cc = cw_cnt;
        int ord = 0;
        int idx = 0;
        run_copy(1'b0, 5, 6, 3, 2);
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 3; c++) begin
                int a = ((6 + r) << X_W) | (5 + c);
                ez[a] = ec[a];
                if (zlog[base + idx] !== ADDR_W'(a)) ord++;
                idx++;
            end
        end
        chk(zlog_n - base == 6, "R7 six depth writes", zlog_n - base, 6);
        chk(ord == 0, "R7 raster order", ord, 0);
        chk(cw_cnt == cc, "R7 colour untouched", cw_cnt - cc, 0);
        cmp_mem("R7 saved contents");
    endtask

    task automatic t_restore;
        int zc = zw_cnt;
        // Overwrite two saved pixels through fragments with the test bypassed.
        cfg_test_en = 1'b0;
        cfg_zwrite_en = 1'b0;
        send_frag(5, 6, 0, 24'h111111);
        send_frag(7, 7, 0, 24'h222222);
        cfg_test_en = 1'b1;
        cfg_zwrite_en = 1'b1;
        ec[(6 << X_W) | 5] = 24'h111111;
        ec[63] = 24'h222222;
        run_copy(1'b1, 5, 6, 3, 2);
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++)
                ec[((6 + r) << X_W) | (5 + c)] = ez[((6 + r) << X_W) | (5 + c)];
        chk(zw_cnt == zc, "R8 depth untouched", zw_cnt - zc, 0);
        cmp_mem("R8 restored contents");
    endtask

    task automatic t_empty;
        int zc = zw_cnt;
        int cc = cw_cnt;
        run_copy(1'b0, 2, 2, 0, 4);
        run_copy(1'b1, 2, 2, 4, 0);
        chk(zw_cnt == zc && cw_cnt == cc, "R9 empty rectangle no access",
            zw_cnt - zc + cw_cnt - cc, 0);
    endtask

    task automatic t_start_ignored;
        int zc = zw_cnt;
        int dn = 0;
        @(negedge clk);
        frag_x = 3'd0; frag_y = 3'd0; frag_z = 24'h000001; frag_color = 24'hCAFE00;
        frag_valid = 1'b1;
        @(negedge clk);
        frag_valid = 1'b0;
        cp_dir = 1'b0; cp_x = 3'd0; cp_y = 3'd0; cp_w = 4'd2; cp_h = 4'd2;
        cp_start = 1'b1;
        chk(frag_ready == 1'b0, "R10 ready low with start high", int'(frag_ready), 0);
        @(negedge clk);
        cp_start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (cp_done) dn++;
            @(negedge clk);
        end
        ez[0] = 24'h000001;
        ec[0] = 24'hCAFE00;
        chk(dn == 0 && zw_cnt - zc == 1, "R10 start during fragment ignored",
            zw_cnt - zc, 1);
        cmp_mem("R10 only the fragment landed");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NPIX; i++) begin
            zmem[i] = 24'hFFFFFF;
            ez[i]   = 24'hFFFFFF;
            cmem[i] = WORD_W'(i * 24'h010203 + 24'h000100);
            ec[i]   = WORD_W'(i * 24'h010203 + 24'h000100);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_fail();
        t_test_off();
        t_zwrite_off();
        t_save();
        t_restore();
        t_empty();
        t_start_ignored();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule